// File: doc/BRIEF.md
# Multi-Mode Down-Counting Timer with Watchdog

This block is a 16-bit down counter behind a small register bus. A coded prescaler sets how many input clocks make one count tick. A two-bit mode field selects one of four behaviours when the count expires:

- free-running wrap-around;
- periodic reload from a stored load value;
- a single timeout that then parks at zero;
- a watchdog that raises a system reset request.

Timer expiries raise a one-cycle interrupt. Watchdog expiries instead drive a fixed-length reset request.

Software arms the timer in two steps. It writes the load value first, then writes the control word with the enable bit set. Any later write of the load value restarts the interval at once. In watchdog mode, that write is how software keeps the system alive.

A sticky flag records that a watchdog expiry happened. It survives the timer reset (`rstN`), so software can read it after the system comes back up. Only the power-on reset (`porN`) or an explicit write-one-to-clear removes it.

Top module: `mode_timer`

## Requirements
- R1: After power-on reset (`porN` and `rstN` both low), all four registers read 0, and `irq` and `sysRstReq` are low.
- R2: A bus write to offset 0x00 loads bits 15:0 into the counter on the next clock edge and clears the prescaler. A read of offset 0x00 returns the current count. Read data appears on `busRdata` one cycle after `busRe`.
- R3: While enable (control bit 7 at offset 0x08) is 0, the count holds its value and no expiry event occurs.
- R4: Control bits 3:0 hold the prescaler code. Codes 0 to 14 give one tick every 2^code clocks. Code 15 gives one tick every 65536 clocks. With load L and code c, the first expiry comes L·2^code clocks after the load write or enable write (65536·L for code 15).
- R5: Mode 0 (free-running, control bits 5:4) pulses `irq` for one cycle on expiry. The count then wraps to 0xFFFF and keeps counting, so the next expiry is 65535 ticks later.
- R6: Mode 1 (periodic) pulses `irq` and reloads the stored load value, giving one `irq` every L ticks.
- R7: Mode 2 (timeout) pulses `irq` once, then holds the count at 0 with no further events until the load register is written again.
- R8: Mode 3 (watchdog) does not raise `irq`. On expiry it asserts `sysRstReq` for exactly 16 cycles, then clears the enable bit. Status bit 5 at offset 0x04 reads 1 while the request is active.
- R9: In watchdog mode, each write to offset 0x00 restarts the interval. If writes come more often than the interval, `sysRstReq` never rises.
- R10: A watchdog expiry sets bit 1 at offset 0x0C. The flag is not cleared by `rstN`, and a write of 0 to it has no effect. Only a write with bit 1 set, or `porN`, clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset, active low; clears everything including the cause flag |
| rstN | input | 1 | Timer reset, active low; leaves the cause flag alone |
| busWe | input | 1 | Register write strobe |
| busRe | input | 1 | Register read strobe |
| busAddr | input | 4 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, registered |
| irq | output | 1 | One-cycle expiry pulse (modes 0 to 2) |
| sysRstReq | output | 1 | Watchdog reset request, 16 cycles wide |

## Verification
Expiry timing is counted from the clock edge that captures the load write or the enable write. An `irq` pulse or the rise of `sysRstReq` is due exactly L·D edges after that edge, where D is the prescaler ratio. The request then stays high for 16 cycles. The driver records the edge index of each write and pushes an item stamped with that due cycle. The monitor compares every observed event against the head of the queue at the falling edge, so an early, late or unexpected event is reported. Register reads are compared against the value held before the sampling edge, because the read data is registered.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;
  localparam int CNT_W = 16;
  localparam int PS_W  = 4;

  typedef enum logic [1:0] {
    MODE_FREE     = 2'd0,
    MODE_PERIODIC = 2'd1,
    MODE_ONESHOT  = 2'd2,
    MODE_WDOG     = 2'd3
  } tmrMode_e;

  localparam logic [3:0] OFF_LOAD  = 4'h0;
  localparam logic [3:0] OFF_STAT  = 4'h4;
  localparam logic [3:0] OFF_CTRL  = 4'h8;
  localparam logic [3:0] OFF_CAUSE = 4'hC;

  localparam int EN_BIT       = 7;
  localparam int MODE_LSB     = 4;
  localparam int STAT_RST_BIT = 5;
  localparam int CAUSE_BIT    = 1;

  // strobes from control to datapath
  typedef struct packed {
    logic             loadWr;
    logic [CNT_W-1:0] loadVal;
    logic             run;
    tmrMode_e         mode;
    logic [PS_W-1:0]  psCode;
  } tmrStrb_t;
endpackage

// File: rtl/mtmr_prescale.sv
module mtmr_prescale #(
  parameter int PS_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            clear,
  input  logic            run,
  input  logic [PS_W-1:0] code,
  output logic            tick
);
  localparam int PS_CNT_W = 2 ** PS_W;

  logic [PS_CNT_W-1:0] psCnt;
  logic [PS_CNT_W-1:0] psMask;
  int                  divExp;

  // top code jumps to the full counter width, others give 2^code
  always_comb begin
    divExp = (code == '1) ? PS_CNT_W : int'(code);
    psMask = '0;
    for (int i = 0; i < PS_CNT_W; i++) begin
      if (i < divExp) psMask[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      psCnt <= '0;
    else if (clear) psCnt <= '0;
    else if (run)   psCnt <= psCnt + 1'b1;
  end

  assign tick = run && ((psCnt & psMask) == psMask);

  // R4: the prescaler restarts from zero after a clear
  a_r4_clear_restarts : assert property (@(posedge clk) disable iff (!rstN)
    clear |=> psCnt == '0);
endmodule

// File: rtl/mtmr_datapath.sv
module mtmr_datapath
  import mtmr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrb_t         strb,
  output logic [CNT_W-1:0] count,
  output logic             expireNow
);
  logic [CNT_W-1:0] loadReg;
  logic             halted;
  logic             psTick;
  logic             tick;

  mtmr_prescale #(.PS_W(PS_W)) prescale_i (
    .clk   (clk),
    .rstN  (rstN),
    .clear (strb.loadWr),
    .run   (strb.run && !halted),
    .code  (strb.psCode),
    .tick  (psTick)
  );

  assign tick      = psTick && !strb.loadWr && !halted;
  assign expireNow = tick && (count <= CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      loadReg <= '0;
      halted  <= 1'b0;
    end else if (strb.loadWr) begin
      count   <= strb.loadVal;
      loadReg <= strb.loadVal;
      halted  <= 1'b0;
    end else if (tick) begin
      if (count <= CNT_W'(1)) begin
        unique case (strb.mode)
          MODE_FREE:     count <= '1;
          MODE_PERIODIC: count <= loadReg;
          default: begin
            count  <= '0;
            halted <= 1'b1;
          end
        endcase
      end else begin
        count <= count - 1'b1;
      end
    end
  end

  // R2: a load write lands in the counter on the next edge
  a_r2_load_lands : assert property (@(posedge clk) disable iff (!rstN)
    strb.loadWr |=> count == $past(strb.loadVal));
  // R3: disabled counter holds
  a_r3_hold_when_off : assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run && !strb.loadWr) |=> $stable(count));
  // R7: a parked counter stays at zero until reloaded
  a_r7_parked_zero : assert property (@(posedge clk) disable iff (!rstN)
    (halted && !strb.loadWr) |=> (count == '0) && !expireNow);
endmodule

// File: rtl/mtmr_ctrl.sv
module mtmr_ctrl
  import mtmr_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter int RST_PULSE = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              porN,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              expireNow,
  output tmrStrb_t          strb,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq,
  output logic              sysRstReq
);
  localparam int RC_W = $clog2(RST_PULSE + 1);

  logic            ctrlEn;
  tmrMode_e        ctrlMode;
  logic [PS_W-1:0] ctrlPs;
  logic [RC_W-1:0] rstCnt;
  logic            causeFlag;
  logic            loadWr, ctrlWr, causeWr;
  logic            wdogHit;
  logic [DATA_W-1:0] rdNext;
  logic            unusedBits;

  assign loadWr  = busWe && (busAddr == ADDR_W'(OFF_LOAD));
  assign ctrlWr  = busWe && (busAddr == ADDR_W'(OFF_CTRL));
  assign causeWr = busWe && (busAddr == ADDR_W'(OFF_CAUSE));
  assign wdogHit = expireNow && (ctrlMode == MODE_WDOG);
  assign unusedBits = ^busWdata[DATA_W-1:CNT_W];

  assign strb.loadWr  = loadWr;
  assign strb.loadVal = busWdata[CNT_W-1:0];
  assign strb.run     = ctrlEn;
  assign strb.mode    = ctrlMode;
  assign strb.psCode  = ctrlPs;

  assign sysRstReq = (rstCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlEn   <= 1'b0;
      ctrlMode <= MODE_FREE;
      ctrlPs   <= '0;
      rstCnt   <= '0;
      irq      <= 1'b0;
    end else begin
      irq <= expireNow && (ctrlMode != MODE_WDOG);
      if (ctrlWr) begin
        ctrlMode <= tmrMode_e'(busWdata[MODE_LSB +: 2]);
        ctrlPs   <= busWdata[PS_W-1:0];
      end
      if (rstCnt == RC_W'(1))  ctrlEn <= 1'b0;
      else if (ctrlWr)         ctrlEn <= busWdata[EN_BIT];
      if (wdogHit)             rstCnt <= RC_W'(RST_PULSE);
      else if (rstCnt != '0)   rstCnt <= rstCnt - 1'b1;
    end
  end

  // cause flag lives on the power-on reset only
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                                  causeFlag <= 1'b0;
    else if (wdogHit)                           causeFlag <= 1'b1;
    else if (causeWr && busWdata[CAUSE_BIT])    causeFlag <= 1'b0;
  end

  always_comb begin
    rdNext = '0;
    unique case (busAddr)
      ADDR_W'(OFF_LOAD):  rdNext[CNT_W-1:0] = count;
      ADDR_W'(OFF_STAT):  rdNext[STAT_RST_BIT] = sysRstReq;
      ADDR_W'(OFF_CTRL): begin
        rdNext[EN_BIT]           = ctrlEn;
        rdNext[MODE_LSB +: 2]    = ctrlMode;
        rdNext[PS_W-1:0]         = ctrlPs;
      end
      ADDR_W'(OFF_CAUSE): rdNext[CAUSE_BIT] = causeFlag;
      default:            rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      busRdata <= '0;
    else if (busRe) busRdata <= rdNext;
  end

  // R8: when the reset request ends, counting is disabled
  a_r8_end_disables : assert property (@(posedge clk) disable iff (!rstN)
    $fell(sysRstReq) |-> !ctrlEn);
  // R8: watchdog mode never raises the interrupt
  a_r8_no_irq_wdog : assert property (@(posedge clk) disable iff (!rstN)
    (ctrlMode == MODE_WDOG && !$past(ctrlWr)) |-> !irq);
  // R10: the flag only drops on a write-one-to-clear
  a_r10_cause_sticky : assert property (@(posedge clk) disable iff (!porN)
    (causeFlag && !(causeWr && busWdata[CAUSE_BIT])) |=> causeFlag);
endmodule

// File: rtl/mode_timer.sv
module mode_timer
  import mtmr_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter int RST_PULSE = 16
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstN,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq,
  output logic              sysRstReq
);
  logic             coreRstN;
  tmrStrb_t         strb;
  logic [CNT_W-1:0] count;
  logic             expireNow;

  assign coreRstN = rstN && porN;

  mtmr_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RST_PULSE(RST_PULSE)) ctrl_i (
    .clk       (clk),
    .rstN      (coreRstN),
    .porN      (porN),
    .busWe     (busWe),
    .busRe     (busRe),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .count     (count),
    .expireNow (expireNow),
    .strb      (strb),
    .busRdata  (busRdata),
    .irq       (irq),
    .sysRstReq (sysRstReq)
  );

  mtmr_datapath datapath_i (
    .clk       (clk),
    .rstN      (coreRstN),
    .strb      (strb),
    .count     (count),
    .expireNow (expireNow)
  );
endmodule

// File: tb/mode_timer_tb_top.sv
`timescale 1ns/1ps
module mode_timer_tb_top;
  localparam int EV_IRQ = 1;
  localparam int EV_RST = 2;

  typedef struct {
    int     kind;
    longint cyc;
    string  req;
  } expEv_t;

  logic        clk = 1'b0;
  logic        porN = 1'b0, rstN = 1'b0;
  logic        busWe = 1'b0, busRe = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq, sysRstReq;

  longint cyc = 0;
  int     nTests = 0, nFail = 0;
  bit     monOn = 1'b0;
  expEv_t expQ[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mode_timer dut_i (
    .clk(clk), .porN(porN), .rstN(rstN), .busWe(busWe), .busRe(busRe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irq(irq), .sysRstReq(sysRstReq)
  );

  task automatic check(string req, longint act, longint expv, string what);
    nTests++;
    if (act != expv) begin
      nFail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, expv);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, output longint edgeIdx);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    edgeIdx = cyc;
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d, output longint edgeIdx);
    @(negedge clk);
    busRe = 1'b1; busAddr = a;
    @(posedge clk); #1;
    edgeIdx = cyc;
    busRe = 1'b0;
    d = busRdata;
  endtask

  task automatic waitUntil(longint t);
    while (cyc < t) @(posedge clk);
    #1;
  endtask

  task automatic pushEv(int kind, longint c, string req);
    expEv_t e;
    e.kind = kind; e.cyc = c; e.req = req;
    expQ.push_back(e);
  endtask

  task automatic popCmp(int kind);
    expEv_t e;
    nTests++;
    if (expQ.size() == 0) begin
      nFail++;
      $display("FAIL unexpected event kind=%0d actual_cycle=%0d expected=none", kind, cyc);
    end else begin
      e = expQ.pop_front();
      if (e.kind != kind || e.cyc != cyc) begin
        nFail++;
        $display("FAIL %s event actual kind=%0d cycle=%0d expected kind=%0d cycle=%0d",
                 e.req, kind, cyc, e.kind, e.cyc);
      end
    end
  endtask

  // monitor: compares design events against the scoreboard queue
  bit prevRst = 1'b0;
  int rstLen  = 0;
  always @(negedge clk) begin
    if (monOn) begin
      if (irq) popCmp(EV_IRQ);
      if (sysRstReq && !prevRst) popCmp(EV_RST);
      if (sysRstReq) rstLen++;
      else if (prevRst) begin
        check("R8", rstLen, 16, "reset request width");
        rstLen = 0;
      end
      prevRst = sysRstReq;
    end
  end

  initial begin
    #(200000 * 8);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    longint e0, ec, er, e1, e2, e3;

    repeat (3) @(posedge clk);
    @(negedge clk); porN = 1'b1; rstN = 1'b1;
    monOn = 1'b1;

    // R1: reset state
    check("R1", irq, 0, "irq after reset");
    check("R1", sysRstReq, 0, "sysRstReq after reset");
    rd(4'h0, d, er); check("R1", d, 0, "load reg after reset");
    rd(4'h4, d, er); check("R1", d, 0, "status after reset");
    rd(4'h8, d, er); check("R1", d, 0, "ctrl after reset");
    rd(4'hC, d, er); check("R1", d, 0, "cause after reset");

    // R2 load readback, R3 disabled hold
    wr(4'h0, 32'hABCD_1234, e0);
    rd(4'h0, d, er); check("R2", d, 32'h1234, "load readback");
    repeat (20) @(posedge clk);
    rd(4'h0, d, er); check("R3", d, 32'h1234, "count held while disabled");

    // R6 periodic, div 1, load 10
    wr(4'h0, 10, e0);
    wr(4'h8, 32'h90, ec);
    pushEv(EV_IRQ, ec + 10, "R6"); pushEv(EV_IRQ, ec + 20, "R6"); pushEv(EV_IRQ, ec + 30, "R6");
    waitUntil(ec + 32);
    wr(4'h8, 32'h10, e0);

    // R4 prescaler code 3 (div 8), periodic load 5
    wr(4'h0, 5, e0);
    wr(4'h8, 32'h93, ec);
    pushEv(EV_IRQ, ec + 40, "R4"); pushEv(EV_IRQ, ec + 80, "R4");
    waitUntil(ec + 82);
    wr(4'h8, 32'h0, e0);

    // R7 timeout, div 2, load 7
    wr(4'h0, 7, e0);
    wr(4'h8, 32'hA1, ec);
    pushEv(EV_IRQ, ec + 14, "R7");
    waitUntil(ec + 60);
    rd(4'h0, d, er); check("R7", d, 0, "timeout parks at zero");
    wr(4'h0, 3, e0);
    pushEv(EV_IRQ, e0 + 6, "R7");
    waitUntil(e0 + 20);
    wr(4'h8, 32'h0, e0);

    // R5 free-running, div 1, load 4
    wr(4'h0, 4, e0);
    wr(4'h8, 32'h80, ec);
    pushEv(EV_IRQ, ec + 4, "R5");
    waitUntil(ec + 10);
    rd(4'h0, d, er);
    check("R5", d, 32'hFFFF - (er - 1 - (ec + 4)), "wrap to 0xFFFF");
    pushEv(EV_IRQ, ec + 4 + 65535, "R5");
    waitUntil(ec + 4 + 65535 + 2);
    wr(4'h8, 32'h0, e0);

    // R4 prescaler code 14 and code 15, periodic load 1
    wr(4'h0, 1, e0);
    wr(4'h8, 32'h9E, ec);
    pushEv(EV_IRQ, ec + 16384, "R4");
    waitUntil(ec + 16386);
    wr(4'h8, 32'h0, e0);
    wr(4'h0, 1, e0);
    wr(4'h8, 32'h9F, ec);
    pushEv(EV_IRQ, ec + 65536, "R4");
    waitUntil(ec + 65538);
    wr(4'h8, 32'h0, e0);

    // R9 keep-alive, then R8 expiry, R10 cause flag
    wr(4'h0, 20, e0);
    wr(4'h8, 32'hB0, ec);
    waitUntil(ec + 10);  wr(4'h0, 20, e1);
    waitUntil(e1 + 10);  wr(4'h0, 20, e2);
    waitUntil(e2 + 10);  wr(4'h0, 20, e3);
    check("R9", sysRstReq, 0, "no reset while refreshed");
    pushEv(EV_RST, e3 + 20, "R8");
    waitUntil(e3 + 25);
    rd(4'h4, d, er); check("R8", d, 32'h20, "status bit 5 during request");
    waitUntil(e3 + 40);
    rd(4'h8, d, er); check("R8", d, 32'h30, "enable cleared after request");
    rd(4'hC, d, er); check("R10", d, 32'h2, "cause flag set");

    @(negedge clk); rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    rd(4'hC, d, er); check("R10", d, 32'h2, "cause survives rstN");
    rd(4'h8, d, er); check("R1", d, 0, "ctrl cleared by rstN");
    wr(4'hC, 32'h0, e0);
    rd(4'hC, d, er); check("R10", d, 32'h2, "write 0 leaves flag");
    wr(4'hC, 32'h2, e0);
    rd(4'hC, d, er); check("R10", d, 32'h0, "write 1 clears flag");

    repeat (5) @(posedge clk);
    check("R6", expQ.size(), 0, "events left in scoreboard");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule